// File: doc/BRIEF.md
# Page-Mode Nonvolatile Write Controller

This block sequences writes into a byte-wide nonvolatile memory model. A host drives a parallel port with chip enable, write enable and output enable (all active low), an address and a data byte. A write strobe is the interval in which chip enable and write enable are both low while output enable is high. The first strobe of a sequence fixes which page is written. Each strobe then loads one byte into a page buffer at the offset given by the low address bits. When the host stops writing for long enough, or starts a byte too late, the load phase closes. A timed internal program cycle then copies the loaded bytes into the array, and `busy` is high while it runs.

All time windows are counted in clock cycles and set by parameters: the limit between successive strobe starts, the idle window that closes a page, and the program duration. An active-low protect input blocks reads and writes. Pulling it low while a page is loading or programming abandons that page. The array is written only in the final cycle of the program cycle, so an aborted page leaves the array exactly as it was. Reads are registered and return the array byte one cycle after the request.

Top module: `pgw_top`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0 and no page is loading.
- R2: A strobe starts in the first cycle in which `ce_n`=0, `we_n`=0, `oe_n`=1 and `hold_n`=1 all hold, so the later of `ce_n` and `we_n` to fall opens it. The byte offset `addr[5:0]` is sampled in that cycle, and `din` is sampled in the first cycle in which the strobe is seen inactive.
- R3: The page number `addr[ADDR_W-1:6]` is captured at the first strobe of a sequence. Later strobes in the same sequence use only their offset bits, so every byte lands in the first page.
- R4: A strobe cycle with `oe_n`=0 is not a write. It loads nothing and starts no program cycle.
- R5: A strobe starting at most BLC_CYC cycles after the previous start is loaded into the page. A start more than BLC_CYC cycles after the previous one loads nothing and closes the page, and `busy` rises at the next edge.
- R6: When no strobe is active for BL_CYC cycles after the last data latch, `busy` rises exactly BL_CYC cycles after the latching edge.
- R7: `busy` stays high for exactly WC_CYC cycles. At its end, every loaded offset of the page holds its data and every offset that was not loaded keeps its old value.
- R8: While `busy` is 1, reads return `rd_valid`=0 and strobes are ignored.
- R9: While `hold_n`=0, reads return `rd_valid`=0 and strobes load nothing.
- R10: `hold_n`=0 during a program cycle drops `busy` at the next edge and leaves the array unchanged. `hold_n`=0 during loading discards the page, and no program cycle follows.
- R11: A read (`ce_n`=0, `oe_n`=0, `we_n`=1, `hold_n`=1, not busy) gives `rd_valid`=1 and `rd_data` = array byte at `addr` one cycle later.
- R12: An offset loaded twice in one page keeps the data of the last load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| hold_n | input | 1 | Active-low protect: blocks access and aborts a page |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address; upper bits page, low 6 bits offset |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, 0 when no read is served |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Program cycle running |

## Verification
The bench builds the block with an 11-bit address, a byte-load limit of 20 cycles, an idle window of 40 cycles and a program time of 30 cycles. These short windows put the exact late-start boundary (20 cycles accepted, 21 rejected), the idle-to-busy delay and the full busy duration within a few hundred cycles. They also leave enough busy time to issue an ignored strobe and a blocked read inside one program cycle, and to abort both a loading page and a running program with the protect input.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        PGW_IDLE = 2'd0,
        PGW_LOAD = 2'd1,
        PGW_PROG = 2'd2
    } pgw_state_e;

    function automatic int pgw_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgw_strobe.sv
// Combines the active-low controls into one write strobe and reports its edges.
module pgw_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic hold_n,
    output logic stb_start,
    output logic stb_end,
    output logic stb_level
);
    logic stb_now;
    logic stb_d, stb_q;

    assign stb_now = ~ce_n & ~we_n & oe_n & hold_n;

    always_comb begin
        stb_d = stb_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_d;
    end

    assign stb_start = stb_now & ~stb_q;
    assign stb_end   = ~stb_now & stb_q;
    assign stb_level = stb_q;
endmodule

// File: rtl/pgw_pagebuf.sv
// Page buffer: one data byte and one loaded flag per offset.
module pgw_pagebuf #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 wr_en,
    input  logic [OFF_W-1:0]                     wr_off,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]    bytes,
    output logic [PAGE_BYTES-1:0]                mask
);
    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_d, data_q;
    logic [PAGE_BYTES-1:0]             mask_d, mask_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == OFF_W'(g));
        always_comb begin
            data_d[g] = hit ? wr_data : data_q[g];
            mask_d[g] = clr ? 1'b0 : (hit | mask_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else begin
            data_q <= data_d;
            mask_q <= mask_d;
        end
    end

    assign bytes = data_q;
    assign mask  = mask_q;
endmodule

// File: rtl/pgw_array.sv
// Behavioural byte array: page-wide masked commit, registered read port.
module pgw_array #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [PG_W-1:0]                   commit_page,
    input  logic [PAGE_BYTES-1:0]             commit_mask,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] commit_bytes,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_valid
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdat_d, rdat_q;
    logic              rvld_d, rvld_q;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (commit_mask[i]) mem[{commit_page, OFF_W'(i)}] <= commit_bytes[i];
            end
        end
    end

    always_comb begin
        rvld_d = rd_en;
        rdat_d = rd_en ? mem[rd_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdat_q <= '0;
            rvld_q <= 1'b0;
        end else begin
            rdat_q <= rdat_d;
            rvld_q <= rvld_d;
        end
    end

    assign rd_data  = rdat_q;
    assign rd_valid = rvld_q;
endmodule

// File: rtl/pgw_top.sv
// Page-mode write sequencer: load window, idle close, timed program, abort.
module pgw_top
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int BLC_CYC    = 1500,
    parameter int BL_CYC     = 5000,
    parameter int WC_CYC     = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int CNT_W = $clog2(pgw_max3(BLC_CYC, BL_CYC, WC_CYC) + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        pgw_state_e       st;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
        logic [CNT_W-1:0] fall_age;
        logic [CNT_W-1:0] rise_age;
        logic [CNT_W-1:0] prog_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic stb_start, stb_end, stb_level;
    logic buf_wr, buf_clr, commit, rd_en;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_bytes;
    logic [PAGE_BYTES-1:0]             buf_mask;

    pgw_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .hold_n    (hold_n),
        .stb_start (stb_start),
        .stb_end   (stb_end),
        .stb_level (stb_level)
    );

    always_comb begin
        ctl_d   = ctl_q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        commit  = 1'b0;
        unique case (ctl_q.st)
            PGW_IDLE: begin
                if (stb_start) begin
                    ctl_d.st       = PGW_LOAD;
                    ctl_d.page     = addr[ADDR_W-1:OFF_W];
                    ctl_d.off      = addr[OFF_W-1:0];
                    ctl_d.fall_age = '0;
                    ctl_d.rise_age = '0;
                end
            end
            PGW_LOAD: begin
                ctl_d.fall_age = (ctl_q.fall_age == CNT_MAX) ? CNT_MAX : ctl_q.fall_age + 1'b1;
                ctl_d.rise_age = (ctl_q.rise_age == CNT_MAX) ? CNT_MAX : ctl_q.rise_age + 1'b1;
                if (stb_start) begin
                    if (ctl_q.fall_age >= CNT_W'(BLC_CYC)) begin
                        ctl_d.st       = PGW_PROG;
                        ctl_d.prog_cnt = '0;
                    end else begin
                        ctl_d.off      = addr[OFF_W-1:0];
                        ctl_d.fall_age = '0;
                        ctl_d.rise_age = '0;
                    end
                end else if (stb_end) begin
                    buf_wr         = 1'b1;
                    ctl_d.rise_age = '0;
                end else if (!stb_level && ctl_q.rise_age >= CNT_W'(BL_CYC - 1)) begin
                    ctl_d.st       = PGW_PROG;
                    ctl_d.prog_cnt = '0;
                end
            end
            PGW_PROG: begin
                if (ctl_q.prog_cnt == CNT_W'(WC_CYC - 1)) begin
                    commit   = 1'b1;
                    buf_clr  = 1'b1;
                    ctl_d.st = PGW_IDLE;
                end else begin
                    ctl_d.prog_cnt = ctl_q.prog_cnt + 1'b1;
                end
            end
            default: ctl_d.st = PGW_IDLE;
        endcase
        if (!hold_n) begin
            ctl_d.st = PGW_IDLE;
            buf_wr   = 1'b0;
            buf_clr  = 1'b1;
            commit   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pgw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_off  (ctl_q.off),
        .wr_data (din),
        .bytes   (buf_bytes),
        .mask    (buf_mask)
    );

    assign rd_en = ~ce_n & ~oe_n & we_n & hold_n & (ctl_q.st != PGW_PROG);

    pgw_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .commit_page  (ctl_q.page),
        .commit_mask  (buf_mask),
        .commit_bytes (buf_bytes),
        .rd_en        (rd_en),
        .rd_addr      (addr),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid)
    );

    assign busy = (ctl_q.st == PGW_PROG);
endmodule

// File: rtl/pgw_top_chk.sv
// Property checker attached to the write sequencer.
module pgw_top_chk #(
    parameter int WC_CYC = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic hold_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic busy,
    input logic rd_valid
);
    int busy_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len_q <= 0;
        else if (busy) busy_len_q <= busy_len_q + 1;
        else           busy_len_q <= 0;
    end

    // R10: protect low ends a program cycle at the next edge
    a_r10_abort_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> !busy);

    // R9: protect low blocks reads
    a_r9_hold_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> !rd_valid);

    // R8: no read is served during a program cycle
    a_r8_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    // R11: an allowed read is answered one cycle later
    a_r11_read_served: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && hold_n && !busy) |=> rd_valid);

    // R7: an unaborted program cycle lasts exactly WC_CYC cycles
    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(hold_n)) |-> (busy_len_q == WC_CYC));
endmodule

bind pgw_top pgw_top_chk #(.WC_CYC(WC_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_n   (hold_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .busy     (busy),
    .rd_valid (rd_valid)
);

// File: tb/tb_pgw_top.sv
module tb_pgw_top;
    localparam int AW  = 11;
    localparam int BLC = 20;
    localparam int BL  = 40;
    localparam int WC  = 30;
    localparam int NV  = 5;
    // each entry {address, data}
    localparam logic [AW+7:0] VEC [NV] = '{
        {11'h140, 8'h11}, {11'h141, 8'h22}, {11'h17F, 8'h33},
        {11'h141, 8'h44}, {11'h1CA, 8'h55}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, hold_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] rd_data;
    logic rd_valid, busy;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    pgw_top #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(64),
              .BLC_CYC(BLC), .BL_CYC(BL), .WC_CYC(WC)) dut (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; oe_n = oe;
        @(negedge clk); we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic v, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = rd_valid; d = rd_data;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!busy && n < 1000) begin @(posedge clk); #1; n++; end
        while (busy && n < 2000) begin @(posedge clk); #1; n++; end
    endtask

    task automatic quiet(input int cyc, output int seen);
        seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(posedge clk); #1;
            if (busy) seen++;
        end
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] e, input string req);
        logic v;
        logic [7:0] d;
        rd(a, v, d);
        chk(v === 1'b1 && d === e, req, int'({v, d}), int'({1'b1, e}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int seen;
        logic v;
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && rd_valid === 1'b0, "R1 reset", int'({busy, rd_valid}), 0);
        quiet(BL + 5, seen);
        chk(seen == 0, "R1 no program without load", seen, 0);

        // Table walk: one page, page bits of first strobe, duplicate offset
        for (int i = 0; i < NV; i++) wr(VEC[i][AW+7:8], VEC[i][7:0], 1'b1);
        n = 0;
        while (!busy && n < 1000) begin @(posedge clk); #1; n++; end
        chk(n == BL, "R6 idle delay", n, BL);
        n = 0;
        while (busy && n < 1000) begin @(posedge clk); #1; n++; end
        chk(n == WC, "R7 busy length", n, WC);
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] la;
            logic [7:0] ed;
            la = {VEC[0][AW+7:14], VEC[i][13:8]};
            ed = VEC[i][7:0];
            for (int j = i + 1; j < NV; j++)
                if (VEC[j][13:8] == VEC[i][13:8]) ed = VEC[j][7:0];
            rd_chk(la, ed, "R2 R3 R11 R12 page load");
        end

        // R7: second program touches one offset only
        wr(11'h141, 8'h66, 1'b1);
        wait_done();
        rd_chk(11'h141, 8'h66, "R7 loaded offset");
        rd_chk(11'h140, 8'h11, "R7 unloaded offset 0 kept");
        rd_chk(11'h17F, 8'h33, "R7 unloaded offset 63 kept");

        // R4: output enable low during the strobe
        wr(11'h140, 8'h99, 1'b0);
        quiet(BL + WC + 10, seen);
        chk(seen == 0, "R4 no program", seen, 0);
        rd_chk(11'h140, 8'h11, "R4 data unchanged");

        // R5: late-start boundary, then R8 inside the program cycle
        wr(11'h242, 8'h5A, 1'b1);
        wait_done();
        wr(11'h240, 8'hA0, 1'b1);
        repeat (15) @(negedge clk);
        wr(11'h241, 8'hA1, 1'b1);
        repeat (16) @(negedge clk);
        wr(11'h242, 8'hA2, 1'b1);
        chk(busy === 1'b1, "R5 late start closes page", int'(busy), 1);
        rd(11'h240, v, d);
        chk(v === 1'b0, "R8 read while busy", int'(v), 0);
        wr(11'h240, 8'hEE, 1'b1);
        chk(busy === 1'b1, "R8 still busy", int'(busy), 1);
        wait_done();
        rd_chk(11'h240, 8'hA0, "R5 R8 first byte, busy strobe ignored");
        rd_chk(11'h241, 8'hA1, "R5 start at limit accepted");
        rd_chk(11'h242, 8'h5A, "R5 late byte dropped");

        // R10: abort during program
        wr(11'h240, 8'h77, 1'b1);
        n = 0;
        while (!busy && n < 1000) begin @(posedge clk); #1; n++; end
        repeat (5) @(negedge clk);
        hold_n = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R10 busy drops on abort", int'(busy), 0);
        hold_n = 1'b1;
        quiet(BL + WC, seen);
        chk(seen == 0, "R10 no restart", seen, 0);
        rd_chk(11'h240, 8'hA0, "R10 array unchanged after abort");

        // R10: abort during loading
        wr(11'h240, 8'h66, 1'b1);
        repeat (3) @(negedge clk);
        hold_n = 1'b0;
        @(negedge clk);
        hold_n = 1'b1;
        quiet(BL + WC, seen);
        chk(seen == 0, "R10 load discarded", seen, 0);
        rd_chk(11'h240, 8'hA0, "R10 array unchanged after load abort");

        // R9: protect low blocks reads and writes
        @(negedge clk); hold_n = 1'b0;
        rd(11'h240, v, d);
        chk(v === 1'b0, "R9 read blocked", int'(v), 0);
        wr(11'h240, 8'h12, 1'b1);
        quiet(BL + WC, seen);
        chk(seen == 0, "R9 write blocked", seen, 0);
        @(negedge clk); hold_n = 1'b1;
        rd_chk(11'h240, 8'hA0, "R9 data unchanged");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule